// File: doc/BRIEF.md
# Barker Chip Spreader

This block turns a stream of already-scrambled data bits into direct-sequence spread chips. Every symbol period is cut into eleven chips, and each chip is one element of a fixed 11-element Barker sequence. The whole sequence is rotated by a carrier phase. That phase is carried as a 2-bit quarter-turn count and is driven onto an in-phase rail and a quadrature rail. The rotation is differential: each symbol's data selects a phase step, and the step is added to the phase of the symbol before it.

A rate select chooses the symbol format. In the one-bit format (differential BPSK) a symbol moves the phase by zero or by a half turn. In the two-bit format (differential QPSK) a symbol moves it by any of four quarter-turn steps. Chips are produced only on the cycles that follow a chip-enable strobe, which an upstream timing source raises eleven times per symbol. The block asks for the next symbol's bits with a one-cycle request pulse. A packet-start pulse returns the phase and the chip position to zero.

Top module: `barker_spreader`

## Requirements
- R1: While rst_n is low and after it is released, chip_vld and bit_req are 0, chip_i and chip_q are 0, and the first symbol after release starts from phase 0 and chip position 0.
- R2: Successive strobes walk the chip position 0,1,...,10 and then wrap to 0. Position k carries the Barker sign +1 -1 +1 +1 -1 +1 +1 +1 -1 -1 -1 (position 0 first) before rotation.
- R3: One cycle after a chip_en strobe, chip_vld is 1 and each rail holds +1 (2'b01) or -1 (2'b11). On every other cycle chip_vld is 0 and both rails hold 0.
- R4: rate_sel, bit_first and bit_second are sampled only on the strobe of chip position 0. Changes to them at any other position have no effect on the chips of the current symbol.
- R5: With rate_sel=0, bit_first=1 leaves the phase unchanged and bit_first=0 adds a half turn (2 quarters). bit_second is ignored.
- R6: With rate_sel=1 the pair (bit_first, bit_second), where bit_first is the earlier bit in time, adds quarter turns as follows: 00 adds 0, 01 adds 1 (+90 degrees), 11 adds 2, 10 adds 3 (-90 degrees).
- R7: For Barker sign s at phase p: p=0 gives I=s, Q=s. p=1 gives I=-s, Q=s. p=2 gives I=-s, Q=-s. p=3 gives I=s, Q=-s.
- R8: bit_req is high for exactly one cycle: the cycle after the strobe of chip position 10, and the cycle after a pkt_start.
- R9: pkt_start clears the phase to 0 and the chip position to 0, even in the middle of a symbol. A chip_en in the same cycle produces no chip.
- R10: The phase accumulates modulo 4 across the symbols of a packet. Each symbol's step is added to the previous symbol's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Packet start pulse; clears phase and chip position |
| chip_en | input | 1 | Chip strobe, eleven per symbol |
| rate_sel | input | 1 | 0: one bit per symbol, 1: two bits per symbol |
| bit_first | input | 1 | Earlier data bit of the symbol (the only bit at rate 0) |
| bit_second | input | 1 | Later data bit of the symbol (rate 1 only) |
| bit_req | output | 1 | One-cycle request for the next symbol's bits |
| chip_vld | output | 1 | Chip outputs valid |
| chip_i | output | 2 | Signed in-phase chip (+1 = 01, -1 = 11, 0 when idle) |
| chip_q | output | 2 | Signed quadrature chip (+1 = 01, -1 = 11, 0 when idle) |

## Verification
Every result here is due exactly one clock after the cause. The chip and its valid flag follow a chip_en strobe after one edge, and the request pulse follows the strobe of chip position 10, or a pkt_start, after one edge. The bench changes inputs on the falling edge and raises a strobe for a single cycle. It reads the rails, chip_vld and bit_req at the next falling edge, then reads them once more on an idle cycle to confirm they have returned to zero. Expected phases in the vector table are accumulated by hand from the step rules. The bench derives the chip values from its own copy of the sign sequence multiplied by the rail signs.

// File: rtl/barker_pkg.sv
package barker_pkg;

  localparam int unsigned SEQ_LEN = 11;
  // bit k = sign of chip position k (1 means +1)
  localparam logic [SEQ_LEN-1:0] SEQ_SIGNS = 11'b000_1110_1101;

  typedef logic [1:0] phase_t;
  typedef logic signed [1:0] chip_t;

  typedef struct packed {
    chip_t i;
    chip_t q;
  } iq_t;

  // quarter-turn step selected by one symbol's data
  function automatic phase_t phase_step(input logic dual, input logic b_early,
                                        input logic b_late);
    phase_t st;
    if (dual) begin
      case ({b_early, b_late})
        2'b00:   st = 2'd0;
        2'b01:   st = 2'd1;
        2'b11:   st = 2'd2;
        default: st = 2'd3;
      endcase
    end else begin
      st = b_early ? 2'd0 : 2'd2;
    end
    return st;
  endfunction

  function automatic chip_t polar(input logic positive);
    return positive ? 2'sb01 : 2'sb11;
  endfunction

  // rotate the pair (s, s) by p quarter turns
  function automatic iq_t rotate(input phase_t p, input logic positive);
    iq_t r;
    logic flip_i, flip_q;
    flip_i = (p == 2'd1) || (p == 2'd2);
    flip_q = p[1];
    r.i = polar(positive ^ flip_i);
    r.q = polar(positive ^ flip_q);
    return r;
  endfunction

endpackage

// File: rtl/barker_chip_counter.sv
module barker_chip_counter #(
  parameter int unsigned CHIPS = 11,
  localparam int unsigned IDX_W = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             sym_first,
  output logic             sym_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHIPS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             take;

  assign take      = step && !restart;
  assign sym_first = take && (idx_q == '0);
  assign sym_last  = take && (idx_q == LAST_IDX);
  assign idx       = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) idx_q <= '0;
    else if (take)         idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_last |=> (idx_q == '0));

  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (idx_q == '0));

endmodule

// File: rtl/barker_phase_tracker.sv
module barker_phase_tracker
  import barker_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   load,
  input  logic   dual,
  input  logic   b_early,
  input  logic   b_late,
  output phase_t sym_phase
);
  phase_t phase_q;
  phase_t next_phase;

  assign next_phase = phase_q + phase_step(dual, b_early, b_late);
  assign sym_phase  = load ? next_phase : phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= 2'd0;
    else if (load)         phase_q <= next_phase;
  end

  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !restart) |=> $stable(phase_q));

  p_half_turn_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !dual && !restart) |=> (phase_q[0] == $past(phase_q[0])));

  p_restart_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == 2'd0));

endmodule

// File: rtl/barker_chip_mapper.sv
module barker_chip_mapper
  import barker_pkg::*;
#(
  parameter int unsigned CHIPS = 11,
  parameter logic [CHIPS-1:0] SIGNS = SEQ_SIGNS,
  localparam int unsigned IDX_W = $clog2(CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic [IDX_W-1:0] idx,
  input  phase_t           phase,
  output logic             vld,
  output chip_t            chip_i,
  output chip_t            chip_q
);
  logic sign_now;
  iq_t  rot;

  assign sign_now = SIGNS[idx];
  assign rot      = rotate(phase, sign_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      chip_i <= '0;
      chip_q <= '0;
    end else begin
      vld    <= emit;
      chip_i <= emit ? rot.i : 2'sb00;
      chip_q <= emit ? rot.q : 2'sb00;
    end
  end

  p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ((chip_i == 2'sb01 || chip_i == 2'sb11) &&
             (chip_q == 2'sb01 || chip_q == 2'sb11)));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (chip_i == 2'sb00 && chip_q == 2'sb00));

endmodule

// File: rtl/barker_spreader.sv
module barker_spreader
  import barker_pkg::*;
#(
  parameter int unsigned CHIPS = SEQ_LEN,
  parameter logic [CHIPS-1:0] SIGNS = SEQ_SIGNS,
  localparam int unsigned IDX_W = $clog2(CHIPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              chip_en,
  input  logic              rate_sel,
  input  logic              bit_first,
  input  logic              bit_second,
  output logic              bit_req,
  output logic              chip_vld,
  output logic signed [1:0] chip_i,
  output logic signed [1:0] chip_q
);
  logic [IDX_W-1:0] chip_idx;
  logic             sym_first;
  logic             sym_last;
  logic             emit;
  phase_t           sym_phase;
  logic             req_q;

  assign emit = chip_en && !pkt_start;

  barker_chip_counter #(.CHIPS(CHIPS)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (pkt_start),
    .step     (chip_en),
    .idx      (chip_idx),
    .sym_first(sym_first),
    .sym_last (sym_last)
  );

  barker_phase_tracker u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (pkt_start),
    .load     (sym_first),
    .dual     (rate_sel),
    .b_early  (bit_first),
    .b_late   (bit_second),
    .sym_phase(sym_phase)
  );

  barker_chip_mapper #(.CHIPS(CHIPS), .SIGNS(SIGNS)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .emit  (emit),
    .idx   (chip_idx),
    .phase (sym_phase),
    .vld   (chip_vld),
    .chip_i(chip_i),
    .chip_q(chip_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= pkt_start || sym_last;
  end
  assign bit_req = req_q;

  p_strobe_to_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !pkt_start) |=> chip_vld);

  p_restart_no_chip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !chip_vld);

  p_req_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_last |=> bit_req);

  p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !pkt_start && !sym_last) |=> !bit_req);

endmodule

// File: tb/barker_spreader_test.sv
module barker_spreader_test;
  logic clk = 1'b0;
  logic rst_n, pkt_start, chip_en, rate_sel, bit_first, bit_second;
  logic bit_req, chip_vld;
  logic signed [1:0] chip_i, chip_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  barker_spreader uut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .chip_en(chip_en),
    .rate_sel(rate_sel), .bit_first(bit_first), .bit_second(bit_second),
    .bit_req(bit_req), .chip_vld(chip_vld), .chip_i(chip_i), .chip_q(chip_q)
  );

  localparam int BAR [11] = '{1, -1, 1, 1, -1, 1, 1, 1, -1, -1, -1};

  // {rate, first, second, expected accumulated phase[1:0]}
  localparam logic [4:0] VEC [10] = '{
    {1'b0, 1'b1, 1'b0, 2'd0},   // R5 keep
    {1'b0, 1'b0, 1'b0, 2'd2},   // R5 half turn
    {1'b0, 1'b0, 1'b1, 2'd0},   // R5 second bit ignored
    {1'b1, 1'b0, 1'b1, 2'd1},   // R6 01 -> +1
    {1'b1, 1'b1, 1'b1, 2'd3},   // R6 11 -> +2
    {1'b1, 1'b1, 1'b0, 2'd2},   // R6 10 -> +3
    {1'b1, 1'b0, 1'b0, 2'd2},   // R6 00 -> +0
    {1'b0, 1'b1, 1'b0, 2'd2},   // R10 hold across rates
    {1'b1, 1'b0, 1'b1, 2'd3},   // R10
    {1'b1, 1'b1, 1'b0, 2'd2}    // R10 wrap modulo 4
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input int v);
    return (v > 0) ? 2'b01 : 2'b11;
  endfunction

  // one strobe at chip position k, expected phase ph
  task automatic do_chip(input int k, input int ph, input bit scramble);
    int s, ei, eq;
    s  = BAR[k];
    ei = ((ph == 1) || (ph == 2)) ? -s : s;
    eq = (ph >= 2) ? -s : s;
    chip_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chip_en = 1'b0;
    check(chip_vld == 1'b1, "R3", "chip_vld", int'(chip_vld), 1);
    check(chip_i == enc(ei), "R7", $sformatf("I chip %0d ph %0d", k, ph),
          int'(chip_i), ei);
    check(chip_q == enc(eq), "R2", $sformatf("Q chip %0d ph %0d", k, ph),
          int'(chip_q), eq);
    check(bit_req == (k == 10), "R8", $sformatf("bit_req chip %0d", k),
          int'(bit_req), int'(k == 10));
    if (scramble && k == 0) begin   // R4: late input changes must not matter
      rate_sel = ~rate_sel; bit_first = ~bit_first; bit_second = ~bit_second;
    end
    @(negedge clk);
    check(!chip_vld && chip_i == 0 && chip_q == 0, "R3", "idle rails",
          int'(chip_vld), 0);
  endtask

  task automatic pulse_start();
    pkt_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_start = 1'b0;
    check(bit_req == 1'b1, "R8", "bit_req after pkt_start", int'(bit_req), 1);
    @(negedge clk);
    check(bit_req == 1'b0, "R8", "bit_req single cycle", int'(bit_req), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pkt_start = 1'b0; chip_en = 1'b0;
    rate_sel = 1'b0; bit_first = 1'b0; bit_second = 1'b0;
    repeat (3) @(negedge clk);
    check(!chip_vld && !bit_req && chip_i == 0 && chip_q == 0, "R1",
          "outputs in reset", int'(chip_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!chip_vld && !bit_req, "R1", "outputs after release",
          int'(bit_req), 0);

    // R1: first symbol after reset, no pkt_start: phase 0, position 0
    rate_sel = 1'b0; bit_first = 1'b1;
    for (int k = 0; k < 11; k++) do_chip(k, 0, 1'b0);

    pulse_start();
    for (int v = 0; v < 10; v++) begin
      rate_sel = VEC[v][4]; bit_first = VEC[v][3]; bit_second = VEC[v][2];
      for (int k = 0; k < 11; k++) do_chip(k, int'(VEC[v][1:0]), 1'b1);
    end

    // R9: restart in mid-symbol (phase is 2 here)
    rate_sel = 1'b1; bit_first = 1'b0; bit_second = 1'b1;
    for (int k = 0; k < 4; k++) do_chip(k, 3, 1'b0);
    pulse_start();
    rate_sel = 1'b0; bit_first = 1'b1;
    for (int k = 0; k < 11; k++) do_chip(k, 0, 1'b0);

    // R9: pkt_start together with chip_en yields no chip
    rate_sel = 1'b1; bit_first = 1'b1; bit_second = 1'b1;
    for (int k = 0; k < 3; k++) do_chip(k, 2, 1'b0);
    pkt_start = 1'b1; chip_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_start = 1'b0; chip_en = 1'b0;
    check(chip_vld == 1'b0, "R9", "no chip with pkt_start", int'(chip_vld), 0);
    rate_sel = 1'b1; bit_first = 1'b0; bit_second = 1'b0;
    for (int k = 0; k < 11; k++) do_chip(k, 0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule